// File: doc/BRIEF.md
# Burst-Mode Supply Phase Sequencer

This block supervises an off-line flyback controller that runs from its own supply capacitor. It steps through three phases in a fixed ring. In the charge phase the high-voltage start source is on. In the switching phase PWM pulses are allowed. In the hold-off phase switching is blocked and the capacitor drains. Each step is taken when a digitized supply-level flag changes. The analog comparators, current sources and PWM pulse generation live outside the block. The block sees them only as level flags and as a per-cycle end report.

The block decides on its own between normal operation and a reduced-peak-current standby. It does this by remembering how the most recent switching cycle ended. A cycle cut short by overcurrent means overload. A cycle ended by PWM compare means a light, reconfigured secondary. When the auxiliary-winding current rises again, the block returns to normal operation at once. Two overvoltage inputs shut off switching until the next charge phase.

All level and protection flags pass through a synchronizer before use. The cycle report is taken as synchronous to `clk`.

Top module: `burst_phase_seq`

## Requirements
- R1: After reset, the block is in the charge phase with `hv_src_en`=1. It moves to switching on the third rising edge after `vcc_gt_start` goes high. In switching, `hv_src_en`=0, `sw_en`=1 and `reg_sw`=1.
- R2: In switching, `vcc_gt_mid` going low moves the block to the hold-off phase. There `sw_en`=0, `reg_sw`=0 and `hv_src_en`=0.
- R3: In hold-off, `vcc_gt_low` going low moves the block back to the charge phase.
- R4: In switching, a `cyc_end` pulse records the cycle end. `cyc_overcur`=0 records "no overcurrent" and `cyc_overcur`=1 records "overcurrent". The record persists across phases.
- R5: On the edge that enters hold-off, the standby mode flag is set if the record says "no overcurrent". On the edge that enters the charge phase, the flag is cleared if the record says "overcurrent". Otherwise the flag keeps its value.
- R6: `stby_sel`=1 exactly while the block is switching with the standby flag set.
- R7: A synchronized high `aux_cur_hi` clears the standby flag on the next edge. The clear wins over a set on the same edge.
- R8: A synchronized `vcc_ovp` or `quick_ovp` outside the charge phase holds `sw_en` at 0 until the block next reaches the charge phase. This holds even after the flag falls.
- R9: `pulse_sw`=1 exactly while the block is in hold-off with the standby flag set.
- R10: Every level and protection input reaches the phase logic through a two-stage synchronizer. A change therefore shows at the outputs on the third rising edge, not earlier.
- R11: Synchronous active-high `rst` clears the synchronizers, the cycle record, the standby flag and the overvoltage latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_gt_start | input | 1 | Supply above the upper start level |
| vcc_gt_mid | input | 1 | Supply above the intermediate stop level |
| vcc_gt_low | input | 1 | Supply above the lower lockout level |
| aux_cur_hi | input | 1 | Auxiliary-winding current above the normal-recovery level |
| vcc_ovp | input | 1 | Supply overvoltage flag |
| quick_ovp | input | 1 | Auxiliary-pin fast overvoltage flag |
| cyc_end | input | 1 | One-cycle pulse at the end of an on-time |
| cyc_overcur | input | 1 | Qualifies `cyc_end`: the on-time ended by overcurrent |
| hv_src_en | output | 1 | Enable for the high-voltage start source |
| sw_en | output | 1 | Permission to emit PWM pulses |
| stby_sel | output | 1 | Selects the reduced peak-current limit |
| pulse_sw | output | 1 | Ties the control pin to its hold-off source |
| reg_sw | output | 1 | Connects the control pin to the shunt regulator |

## Verification
The standby flag can be set on entry to hold-off and cleared by the auxiliary-current flag on the very same edge. The bench provokes this by changing `vcc_gt_mid` and `aux_cur_hi` at the same falling edge, with a "no overcurrent" record already held. Both inputs then pass through the same synchronizer stages and arrive together. The check passes only if the hold-off phase shows `pulse_sw`=0, because the clear must win. A second pairing lets an overvoltage flag arrive while switching. The bench then confirms that `sw_en` stays low after the flag is withdrawn, while the phase ring keeps advancing.

// File: rtl/bmseq_pkg.sv
package bmseq_pkg;

    // one-hot phase encoding
    typedef enum logic [2:0] {
        PH_CHARGE = 3'b001,
        PH_SWITCH = 3'b010,
        PH_HOLD   = 3'b100
    } phase_e;

    // synchronized level and protection flags
    typedef struct packed {
        logic gt_start;
        logic gt_mid;
        logic gt_low;
        logic aux_hi;
        logic ovp_any;
    } lvl_t;

    localparam int LVL_W = $bits(lvl_t);

    // outputs towards the power stage
    typedef struct packed {
        logic hv_src_en;
        logic sw_en;
        logic stby_sel;
        logic pulse_sw;
        logic reg_sw;
    } drv_t;

    function automatic logic phase_legal(input logic [2:0] p);
        return ($countones(p) == 1);
    endfunction

endpackage

// File: rtl/bmseq_sync.sv
module bmseq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[LAST];

endmodule

// File: rtl/bmseq_phase_fsm.sv
module bmseq_phase_fsm
    import bmseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lvl_t   lvl,
    output phase_e phase,
    output logic   enter_hold,
    output logic   enter_charge
);
    phase_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!phase_legal(st_q)) begin
            st_d = PH_CHARGE;
        end else begin
            unique case (st_q)
                PH_CHARGE: if (lvl.gt_start) st_d = PH_SWITCH;
                PH_SWITCH: if (!lvl.gt_mid)  st_d = PH_HOLD;
                PH_HOLD:   if (!lvl.gt_low)  st_d = PH_CHARGE;
                default:   st_d = PH_CHARGE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PH_CHARGE;
        else     st_q <= st_d;
    end

    assign phase        = st_q;
    assign enter_hold   = (st_q == PH_SWITCH) && (st_d == PH_HOLD);
    assign enter_charge = (st_q == PH_HOLD)   && (st_d == PH_CHARGE);

    // R1: the phase register always holds exactly one phase
    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(st_q) == 1);

    // R1: a synchronized start flag in charge leads to switching
    assert_charge_to_switch_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_CHARGE && lvl.gt_start) |=> (st_q == PH_SWITCH));

    // R3: hold-off never jumps straight to switching
    assert_hold_no_skip_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_HOLD) |=> (st_q != PH_SWITCH));

endmodule

// File: rtl/bmseq_mode_latches.sv
module bmseq_mode_latches (
    input  logic clk,
    input  logic rst,
    input  logic in_switch,
    input  logic in_charge,
    input  logic enter_hold,
    input  logic enter_charge,
    input  logic cyc_end,
    input  logic cyc_overcur,
    input  logic aux_hi,
    input  logic ovp_any,
    output logic noc_q,
    output logic mode_q,
    output logic ovp_q
);
    // cycle-end record: 1 = ended by PWM compare, 0 = ended by overcurrent
    always_ff @(posedge clk) begin
        if (rst)                        noc_q <= 1'b0;
        else if (in_switch && cyc_end)  noc_q <= !cyc_overcur;
    end

    // standby mode flag, auxiliary clear has priority
    always_ff @(posedge clk) begin
        if (rst)                          mode_q <= 1'b0;
        else if (aux_hi)                  mode_q <= 1'b0;
        else if (enter_hold && noc_q)     mode_q <= 1'b1;
        else if (enter_charge && !noc_q)  mode_q <= 1'b0;
    end

    // overvoltage latch, released only by the charge phase
    always_ff @(posedge clk) begin
        if (rst)            ovp_q <= 1'b0;
        else if (in_charge) ovp_q <= 1'b0;
        else if (ovp_any)   ovp_q <= 1'b1;
    end

    // R7: auxiliary flag clears the mode on the next edge
    assert_aux_clears_R7: assert property (@(posedge clk) disable iff (rst)
        aux_hi |=> !mode_q);

    // R8: overvoltage latch holds until the charge phase
    assert_ovp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ovp_q && !in_charge) |=> ovp_q);

    // R5: mode only rises on entry to hold-off
    assert_mode_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q) |-> $past(enter_hold));

endmodule

// File: rtl/burst_phase_seq.sv
module burst_phase_seq
    import bmseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vcc_gt_start,
    input  logic vcc_gt_mid,
    input  logic vcc_gt_low,
    input  logic aux_cur_hi,
    input  logic vcc_ovp,
    input  logic quick_ovp,
    input  logic cyc_end,
    input  logic cyc_overcur,
    output logic hv_src_en,
    output logic sw_en,
    output logic stby_sel,
    output logic pulse_sw,
    output logic reg_sw
);
    lvl_t   lvl_raw, lvl_s;
    phase_e phase;
    logic   enter_hold, enter_charge;
    logic   noc_q, mode_q, ovp_q;
    logic   in_switch, in_charge, in_hold;
    drv_t   drv;

    assign lvl_raw = '{gt_start: vcc_gt_start, gt_mid: vcc_gt_mid,
                       gt_low: vcc_gt_low, aux_hi: aux_cur_hi,
                       ovp_any: vcc_ovp | quick_ovp};

    bmseq_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lvl_raw),
        .q   (lvl_s)
    );

    bmseq_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .lvl          (lvl_s),
        .phase        (phase),
        .enter_hold   (enter_hold),
        .enter_charge (enter_charge)
    );

    assign in_switch = (phase == PH_SWITCH);
    assign in_charge = (phase == PH_CHARGE);
    assign in_hold   = (phase == PH_HOLD);

    bmseq_mode_latches u_latch (
        .clk          (clk),
        .rst          (rst),
        .in_switch    (in_switch),
        .in_charge    (in_charge),
        .enter_hold   (enter_hold),
        .enter_charge (enter_charge),
        .cyc_end      (cyc_end),
        .cyc_overcur  (cyc_overcur),
        .aux_hi       (lvl_s.aux_hi),
        .ovp_any      (lvl_s.ovp_any),
        .noc_q        (noc_q),
        .mode_q       (mode_q),
        .ovp_q        (ovp_q)
    );

    always_comb begin
        drv.hv_src_en = in_charge;
        drv.sw_en     = in_switch && !ovp_q;
        drv.stby_sel  = in_switch && mode_q;
        drv.pulse_sw  = in_hold && mode_q;
        drv.reg_sw    = in_switch;
    end

    assign hv_src_en = drv.hv_src_en;
    assign sw_en     = drv.sw_en;
    assign stby_sel  = drv.stby_sel;
    assign pulse_sw  = drv.pulse_sw;
    assign reg_sw    = drv.reg_sw;

    // R2: start source and switching are never on together
    assert_src_sw_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(hv_src_en && (sw_en || reg_sw)));

    // R9: hold-off switch and regulation switch are exclusive
    assert_pin_switch_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(pulse_sw && reg_sw));

    // R6: standby select only while regulating
    assert_stby_in_switch_R6: assert property (@(posedge clk) disable iff (rst)
        stby_sel |-> reg_sw);

endmodule

// File: tb/burst_phase_seq_test.sv
module burst_phase_seq_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_gt_start = 0, vcc_gt_mid = 0, vcc_gt_low = 0;
    logic aux_cur_hi = 0, vcc_ovp = 0, quick_ovp = 0;
    logic cyc_end = 0, cyc_overcur = 0;
    logic hv_src_en, sw_en, stby_sel, pulse_sw, reg_sw;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [4:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    burst_phase_seq uut (
        .clk(clk), .rst(rst),
        .vcc_gt_start(vcc_gt_start), .vcc_gt_mid(vcc_gt_mid), .vcc_gt_low(vcc_gt_low),
        .aux_cur_hi(aux_cur_hi), .vcc_ovp(vcc_ovp), .quick_ovp(quick_ovp),
        .cyc_end(cyc_end), .cyc_overcur(cyc_overcur),
        .hv_src_en(hv_src_en), .sw_en(sw_en), .stby_sel(stby_sel),
        .pulse_sw(pulse_sw), .reg_sw(reg_sw)
    );

    // monitor: {hv_src_en, sw_en, stby_sel, pulse_sw, reg_sw}
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            logic [4:0] got;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = {hv_src_en, sw_en, stby_sel, pulse_sw, reg_sw};
            checks++;
            if (got !== e) begin
                errors++;
                $display("FAIL %s: got %b expected %b", t, got, e);
            end
        end
    end

    task automatic expect_after(input int n, input logic [4:0] e, input string t);
        repeat (n) @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic levels(input logic s, input logic m, input logic l);
        @(negedge clk);
        vcc_gt_start = s; vcc_gt_mid = m; vcc_gt_low = l;
    endtask

    task automatic cycle_end(input logic oc);
        @(negedge clk);
        cyc_end = 1'b1; cyc_overcur = oc;
        @(negedge clk);
        cyc_end = 1'b0; cyc_overcur = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        expect_after(1, 5'b10000, "R11 reset state charge phase");

        levels(0, 1, 1);
        expect_after(4, 5'b10000, "R1 waits for start flag");
        levels(1, 1, 1);
        expect_after(2, 5'b10000, "R10 no change after two edges");
        expect_after(1, 5'b01001, "R10 R1 switching on third edge");

        cycle_end(1);
        expect_after(2, 5'b01001, "R4 overcurrent cycle keeps normal");
        levels(0, 0, 1);
        expect_after(4, 5'b00000, "R2 hold-off after overcurrent record");
        levels(0, 0, 0);
        expect_after(4, 5'b10000, "R3 back to charge");

        levels(1, 1, 1);
        expect_after(4, 5'b01001, "R1 switching normal");
        cycle_end(0);
        expect_after(2, 5'b01001, "R4 record alone changes no output");
        levels(0, 0, 1);
        expect_after(4, 5'b00010, "R5 R9 standby flag set on hold-off entry");
        levels(0, 0, 0);
        expect_after(4, 5'b10000, "R5 flag kept, charge phase");
        levels(1, 1, 1);
        expect_after(4, 5'b01101, "R6 standby select while switching");

        cycle_end(1);
        levels(0, 0, 1);
        expect_after(4, 5'b00010, "R5 overcurrent does not clear on hold-off");
        levels(0, 0, 0);
        expect_after(4, 5'b10000, "R5 charge entry clears after overload");
        levels(1, 1, 1);
        expect_after(4, 5'b01001, "R5 normal after overload");

        cycle_end(0);
        levels(0, 0, 1);
        expect_after(4, 5'b00010, "R9 pulse switch in hold-off");
        @(negedge clk) aux_cur_hi = 1'b1;
        expect_after(4, 5'b00000, "R7 auxiliary flag clears standby");
        @(negedge clk) aux_cur_hi = 1'b0;
        expect_after(4, 5'b00000, "R7 stays cleared");
        levels(0, 0, 0);
        expect_after(4, 5'b10000, "R7 charge phase");
        levels(1, 1, 1);
        expect_after(4, 5'b01001, "R7 normal switching after clear");

        // collision: hold-off entry with noc record and aux clear on one edge
        cycle_end(0);
        @(negedge clk);
        vcc_gt_start = 0; vcc_gt_mid = 0; aux_cur_hi = 1'b1;
        expect_after(4, 5'b00000, "R7 clear wins over set");
        @(negedge clk) aux_cur_hi = 1'b0;
        levels(0, 0, 0);
        expect_after(4, 5'b10000, "R3 charge after collision");
        levels(1, 1, 1);
        expect_after(4, 5'b01001, "R5 no stale standby");

        cycle_end(1);
        @(negedge clk) vcc_ovp = 1'b1;
        expect_after(4, 5'b00001, "R8 supply overvoltage blocks switching");
        @(negedge clk) vcc_ovp = 1'b0;
        expect_after(4, 5'b00001, "R8 block held after flag falls");
        levels(0, 0, 1);
        expect_after(4, 5'b00000, "R8 ring advances to hold-off");
        levels(0, 0, 0);
        expect_after(4, 5'b10000, "R8 charge phase");
        levels(1, 1, 1);
        expect_after(4, 5'b01001, "R8 released by fresh start");
        @(negedge clk) quick_ovp = 1'b1;
        expect_after(4, 5'b00001, "R8 quick overvoltage blocks switching");
        @(negedge clk) quick_ovp = 1'b0;
        expect_after(4, 5'b00001, "R8 quick block held");

        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule